// File: doc/BRIEF.md
# Pulse Accumulator with Interrupt Flags

The block is an 8-bit event counter fed by one external pulse pin. The pin passes through a two-flop synchronizer and an edge detector. In event mode the counter steps once on each selected edge of the pin. In gated mode it steps once per prescaled tick while the pin sits at its active level. Software sees three byte registers on a simple select/write bus: the count, an enable (mask) register and a flag register. The count can be loaded at any time, and reset leaves it untouched.

Two sticky flags record counter wrap and pin activity. A flag clears only when software writes a 1 to its bit position. The enable bits decide only whether a set flag drives the single interrupt line. They never stop a flag from setting. Read data is captured on the falling clock edge, half a cycle away from the rising edge that updates the counter, so a read always returns a settled count. Two static configuration pins choose the mode and the polarity.

Top module: `evt_accum`

## Requirements
- R1: A write to offset 0x27 loads the count. A read of 0x27 returns the count, and read data is captured on the falling clock edge while busSel is high and busWr is low.
- R2: Reset does not alter the count register.
- R3: With cfgGated=0, the count steps by one for each rising edge of pulseIn when cfgPolarity=1, and for each falling edge when cfgPolarity=0. The other edge is ignored.
- R4: With cfgGated=1, the count steps by one on each clock where tickIn is high and the synchronized pulseIn equals cfgPolarity. It holds while pulseIn is inactive.
- R5: Flag bit 5 at offset 0x25 sets when an increment takes the count from 0xFF to 0x00. A software write of any value does not set it.
- R6: Flag bit 4 at offset 0x25 sets on the counted edge in event mode, and on the edge that ends the active level in gated mode.
- R7: Writing 1 to flag bit 5 or bit 4 clears that bit. Writing 0 leaves it unchanged. When a clear and a set land in the same cycle, the flag stays set.
- R8: Enable bits 5 and 4 at offset 0x24 are read/write and have no effect on whether the flags set.
- R9: irqOut is high exactly when some flag bit is set together with the enable bit at the same position.
- R10: When a count write and an increment fall in the same cycle, the written value is kept.
- R11: Bits other than 5 and 4 in the mask and flag registers read 0, and unmapped offsets read 0.
- R12: Reset clears both flags and both enables, so irqOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pulseIn | input | 1 | External pulse pin, asynchronous |
| tickIn | input | 1 | Prescaled tick used in gated mode |
| cfgGated | input | 1 | 1 selects gated mode, 0 selects event mode |
| cfgPolarity | input | 1 | Counted edge (1 = rising) or active level (1 = high) |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, captured on the falling edge |
| irqOut | output | 1 | Interrupt request |

## Verification
Event mode is driven with random pulse trains of random widths under both polarities. Comparing the count with the number of pulses tells the counted edge apart from the ignored one. Gated mode gets random tick patterns inside a held gate, which separates per-tick counting from per-edge counting and checks that ticks outside the gate do nothing. Directed cases place a count load on a clock that also carries an increment, and a flag clear on the clock of a wrap. These show which side wins each collision. Random start counts near 0xFF exercise the wrap flag against a model of the pulse count modulo 256.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam logic [7:0] OFF_COUNT = 8'h27;
  localparam logic [7:0] OFF_MASK  = 8'h24;
  localparam logic [7:0] OFF_FLAG  = 8'h25;
  localparam int BIT_OVF  = 5;
  localparam int BIT_EDGE = 4;

  typedef struct packed {
    logic cntLoad;
    logic maskLoad;
    logic flagClr;
    logic countInc;
    logic edgeSet;
    logic rdCount;
    logic rdMask;
    logic rdFlag;
  } paStrobe_t;
endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CNT_OFF  = ADDR_W'(OFF_COUNT),
  parameter logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(OFF_MASK),
  parameter logic [ADDR_W-1:0] FLAG_OFF = ADDR_W'(OFF_FLAG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic              tickIn,
  input  logic              cfgGated,
  input  logic              cfgPolarity,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output paStrobe_t         stb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic pinNow, riseEdge, fallEdge, leadEdge, trailEdge, lvlActive;
  logic wrAcc, rdAcc;

  // Synchronizer chain; the last stage feeds the edge detector
  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $fatal(1, "SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[LAST-1:0], pulseIn};
      prevQ <= syncQ[LAST];
    end
  end

  always_comb begin
    pinNow    = syncQ[LAST];
    riseEdge  = pinNow & ~prevQ;
    fallEdge  = ~pinNow & prevQ;
    leadEdge  = cfgPolarity ? riseEdge : fallEdge;
    trailEdge = cfgPolarity ? fallEdge : riseEdge;
    lvlActive = (pinNow == cfgPolarity);
    wrAcc     = busSel & busWr;
    rdAcc     = busSel & ~busWr;

    stb          = '0;
    stb.cntLoad  = wrAcc && (busAddr == CNT_OFF);
    stb.maskLoad = wrAcc && (busAddr == MASK_OFF);
    stb.flagClr  = wrAcc && (busAddr == FLAG_OFF);
    stb.rdCount  = rdAcc && (busAddr == CNT_OFF);
    stb.rdMask   = rdAcc && (busAddr == MASK_OFF);
    stb.rdFlag   = rdAcc && (busAddr == FLAG_OFF);
    if (cfgGated) begin
      stb.countInc = lvlActive & tickIn;
      stb.edgeSet  = trailEdge;
    end else begin
      stb.countInc = leadEdge;
      stb.edgeSet  = leadEdge;
    end
  end
endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import pa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVF_POS = BIT_OVF,
  parameter int EDGE_POS = BIT_EDGE
) (
  input  logic              clk,
  input  logic              rstN,
  input  paStrobe_t         stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] flagQ,
  output logic [DATA_W-1:0] maskQ
);
  localparam logic [DATA_W-1:0] IMPL_BITS =
    (DATA_W'(1) << OVF_POS) | (DATA_W'(1) << EDGE_POS);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic ovfEvt;
  logic [DATA_W-1:0] setVec, clrVec, flagD, rdMux;

  // Counter: no reset, software load has priority over an increment
  always_ff @(posedge clk) begin
    if (stb.cntLoad)       cntQ <= busWdata;
    else if (stb.countInc) cntQ <= cntQ + DATA_W'(1);
  end

  always_comb begin
    ovfEvt = stb.countInc & ~stb.cntLoad & (cntQ == CNT_MAX);
    setVec = '0;
    setVec[OVF_POS]  = ovfEvt;
    setVec[EDGE_POS] = stb.edgeSet;
    clrVec = stb.flagClr ? (busWdata & IMPL_BITS) : '0;
    flagD  = (flagQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      flagQ <= flagD;
      if (stb.maskLoad) maskQ <= busWdata & IMPL_BITS;
    end
  end

  assign irqOut = |(flagQ & maskQ);

  always_comb begin
    unique case (1'b1)
      stb.rdCount: rdMux = cntQ;
      stb.rdMask:  rdMux = maskQ;
      stb.rdFlag:  rdMux = flagQ;
      default:     rdMux = '0;
    endcase
  end

  // Read data captured on the opposite clock phase from counter updates
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdMux;
  end
endmodule

// File: rtl/evt_accum.sv
module evt_accum
  import pa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic              tickIn,
  input  logic              cfgGated,
  input  logic              cfgPolarity,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  paStrobe_t stb;
  logic [DATA_W-1:0] cntQ, flagQ, maskQ;

  pa_ctrl #(
    .ADDR_W(ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .tickIn(tickIn),
    .cfgGated(cfgGated), .cfgPolarity(cfgPolarity),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .stb(stb)
  );

  pa_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut),
    .cntQ(cntQ), .flagQ(flagQ), .maskQ(maskQ)
  );
endmodule

// File: rtl/evt_accum_chk.sv
module evt_accum_chk
  import pa_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input paStrobe_t  stb,
  input logic [7:0] busWdata,
  input logic [7:0] cntQ,
  input logic [7:0] flagQ,
  input logic [7:0] maskQ,
  input logic       irqOut
);
  // R9: an enabled set flag drives the request
  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & maskQ) != 8'h00) |-> irqOut);

  // R9: no request without an enabled flag
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((flagQ & maskQ) != 8'h00));

  // R5: wrap by increment sets the overflow flag
  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countInc && !stb.cntLoad && cntQ == 8'hFF) |=> flagQ[BIT_OVF]);

  // R7: a flag only falls after a write of 1 to its position
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ[BIT_OVF]) |-> $past(stb.flagClr && busWdata[BIT_OVF]));

  p_edge_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ[BIT_EDGE]) |-> $past(stb.flagClr && busWdata[BIT_EDGE]));

  // R10: a load always lands, even with a concurrent increment
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntLoad |=> (cntQ == $past(busWdata)));

  // R3: the count moves only on a load or an increment
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.cntLoad && !stb.countInc) |=> $stable(cntQ));

  // R11: unimplemented flag and mask bits stay 0
  p_unimpl_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ | maskQ) & 8'hCF) == 8'h00);
endmodule

bind evt_accum evt_accum_chk u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
  .cntQ(cntQ), .flagQ(flagQ), .maskQ(maskQ), .irqOut(irqOut)
);

// File: tb/evt_accum_tb.sv
`timescale 1ns/1ps
module evt_accum_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic pulseIn = 1'b0, tickIn = 1'b0, cfgGated = 1'b0, cfgPolarity = 1'b1;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = 8'h00, busWdata = 8'h00;
  logic [7:0] busRdata;
  logic irqOut;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  localparam logic [7:0] A_CNT = 8'h27, A_MSK = 8'h24, A_FLG = 8'h25;

  always #2.5 clk = ~clk;

  evt_accum u_dut (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .tickIn(tickIn),
    .cfgGated(cfgGated), .cfgPolarity(cfgPolarity),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic [7:0] addMod(input logic [7:0] a, input int n);
    return 8'((int'(a) + n) % 256);
  endfunction

  function automatic bit wraps(input logic [7:0] a, input int n);
    return (int'(a) + n) > 255;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    busSel = 1; busWr = 0; busAddr = a;
    @(posedge clk); #1;
    d = busRdata;
    busSel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int hi, input int lo);
    pulseIn = 1; idle(hi);
    pulseIn = 0; idle(lo);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] rd, start;
    int n, ones;
    bit expOvf;
    void'($urandom(32'h5EED_1234));

    idle(3); rstN = 1; idle(2);
    // R12: reset state of flags, mask and request
    busRead(A_FLG, rd); check("R12 flags after reset", rd, 8'h00);
    busRead(A_MSK, rd); check("R12 mask after reset", rd, 8'h00);
    check("R12 irq after reset", {7'b0, irqOut}, 8'h00);

    // R1 load and read
    busWrite(A_CNT, 8'h5A);
    busRead(A_CNT, rd); check("R1 count load", rd, 8'h5A);
    // R2 count survives reset
    @(posedge clk); #1; rstN = 0; idle(2); rstN = 1; idle(2);
    busRead(A_CNT, rd); check("R2 count kept across reset", rd, 8'h5A);
    // R11 unmapped offset
    busRead(8'h26, rd); check("R11 unmapped reads 0", rd, 8'h00);
    // R8/R11 mask writable bits only
    busWrite(A_MSK, 8'hFF);
    busRead(A_MSK, rd); check("R8 R11 mask implemented bits", rd, 8'h30);
    busWrite(A_MSK, 8'h00);

    // R5 software write of 0xFF does not set overflow
    busWrite(A_CNT, 8'hFF); idle(2);
    busRead(A_FLG, rd); check("R5 write does not set ovf", rd, 8'h00);

    // R3 rising-edge event mode, directed wrap
    cfgGated = 0; cfgPolarity = 1;
    pulse(4, 4);
    busRead(A_CNT, rd); check("R3 rising edge count wrap", rd, 8'h00);
    busRead(A_FLG, rd); check("R5 R6 wrap and edge flags", rd, 8'h30);
    // R7 write 0 leaves flags, write 1 clears one bit
    busWrite(A_FLG, 8'h00);
    busRead(A_FLG, rd); check("R7 write 0 keeps flags", rd, 8'h30);
    busWrite(A_FLG, 8'h20);
    busRead(A_FLG, rd); check("R7 clear ovf only", rd, 8'h10);
    // R9 request follows enable
    busWrite(A_MSK, 8'h10); idle(1);
    check("R9 irq with edge enable", {7'b0, irqOut}, 8'h01);
    busWrite(A_MSK, 8'h20); idle(1);
    check("R9 irq masked", {7'b0, irqOut}, 8'h00);
    busWrite(A_FLG, 8'hFF);
    busRead(A_FLG, rd); check("R7 clear all", rd, 8'h00);

    // R3 random pulse trains, both polarities
    for (int it = 0; it < 10; it++) begin
      cfgPolarity = it[0];
      pulseIn = ~cfgPolarity ? 1'b0 : 1'b0;
      idle(4);
      start = (it % 3 == 0) ? 8'(8'hF8 + $urandom_range(0, 7)) : 8'($urandom);
      busWrite(A_CNT, start);
      busWrite(A_FLG, 8'h30);
      n = $urandom_range(1, 12);
      for (int p = 0; p < n; p++) pulse($urandom_range(3, 6), $urandom_range(3, 6));
      expOvf = wraps(start, n);
      busRead(A_CNT, rd);
      check(cfgPolarity ? "R3 rising count" : "R3 falling count", rd, addMod(start, n));
      busRead(A_FLG, rd);
      check("R5 R6 random flags", rd, {2'b00, expOvf, 1'b1, 4'h0});
      check("R9 irq ovf enabled", {7'b0, irqOut}, {7'b0, expOvf});
    end

    // R4 gated mode, active high, random ticks
    cfgGated = 1; cfgPolarity = 1; pulseIn = 0; tickIn = 0; idle(4);
    busWrite(A_CNT, 8'h10); busWrite(A_FLG, 8'h30);
    tickIn = 1; idle(6); tickIn = 0;
    busRead(A_CNT, rd); check("R4 ticks ignored outside gate", rd, 8'h10);
    pulseIn = 1; idle(4);
    ones = 0;
    for (int c = 0; c < 30; c++) begin
      tickIn = $urandom_range(0, 1);
      ones += tickIn;
      idle(1);
    end
    tickIn = 0;
    busRead(A_FLG, rd); check("R6 no edge flag inside gate", rd, 8'h00);
    pulseIn = 0; idle(4);
    busRead(A_CNT, rd); check("R4 gated tick count", rd, addMod(8'h10, ones));
    busRead(A_FLG, rd); check("R6 trailing edge flag", rd, 8'h10);

    // R4 gated active low
    cfgPolarity = 0; pulseIn = 1; idle(4);
    busWrite(A_CNT, 8'h00); busWrite(A_FLG, 8'h30);
    tickIn = 1; idle(5); tickIn = 0;
    busRead(A_CNT, rd); check("R4 active-low holds when high", rd, 8'h00);
    pulseIn = 0; idle(3);
    tickIn = 1; idle(7); tickIn = 0;
    pulseIn = 1; idle(4);
    busRead(A_CNT, rd); check("R4 active-low count", rd, 8'h07);
    busRead(A_FLG, rd); check("R6 active-low trailing edge", rd, 8'h10);

    // R10 load during continuous increment
    cfgPolarity = 1; pulseIn = 1; idle(4); tickIn = 1;
    busWrite(A_CNT, 8'h40);
    busRead(A_CNT, rd); check("R10 write wins over increment", rd, 8'h41);

    // R7 set and clear in the same cycle: wrap lands on the clear
    busWrite(A_FLG, 8'h30);
    busWrite(A_CNT, 8'hFE);
    busWrite(A_FLG, 8'h20);
    tickIn = 0;
    busRead(A_FLG, rd); check("R7 set beats clear", {rd[7:6], rd[5], 5'b0}, 8'h20);
    busWrite(A_FLG, 8'h20);
    busRead(A_FLG, rd); check("R7 cleared afterwards", rd & 8'h20, 8'h00);

    pulseIn = 0; idle(4);
    finish_up();
  end
endmodule